// File: doc/BRIEF.md
# Bidirectional GPIO Port Registers

This block is one general-purpose I/O port of configurable width (eight pins by default). Software programs it through a small register bus with an address, a write enable, write data and combinational read data. The port has three register slots. A direction register sets, pin by pin, whether the port drives that pin. An output latch holds the value driven on each output pin. A read-only port view returns, for each bit, either the latched output value or the synchronized level of the pin. The direction bit of that pin selects which one.

Four chip-level controls reach the block separately, because they treat the registers differently. Power-on reset clears the direction register and the output latch, and so does hardware standby for as long as it is asserted. Hardware standby also releases every pin driver at once. Manual reset and software standby keep all register contents. While either one is asserted, the port ignores register writes.

Top module: `gpio_port_regs`

## Requirements
- R1: After power-on reset (porRstN low), the direction register and the output latch are 0: pinOe = 0x00, pinOut = 0x00, and a read of offset 1 returns 0x00.
- R2: A write to offset 1 with regWe high updates the output latch at that clock edge. From then on, a read of offset 1 returns the written value and pinOut equals it.
- R3: A write to offset 0 updates the direction register, and pinOe equals it (bit set = pin driven). A read of offset 0 always returns 0x00.
- R4: A read of offset 2 returns, bit by bit, the output latch bit where the direction bit is 1 and the synchronized pin level where the direction bit is 0.
- R5: A change on pinIn appears in the port-view read after exactly two rising clock edges. It does not appear after one.
- R6: Writes to offset 2 (port view) and offset 3 (unused) change neither register. A read of offset 3 returns 0x00.
- R7: While hwStandby is high, pinOe is 0x00 in the same cycle. At each edge the direction register and the output latch are cleared, and writes are ignored.
- R8: While manualRstN is low, writes are ignored and both registers keep their contents. When it is released, the registers still hold those contents.
- R9: While swStandby is high, writes are ignored and both registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low; clears all state |
| manualRstN | input | 1 | Manual reset, active low; holds registers, blocks writes |
| hwStandby | input | 1 | Hardware standby; clears registers, releases all pins |
| swStandby | input | 1 | Software standby; holds registers, blocks writes |
| regAddr | input | 2 | Register offset: 0 direction, 1 output latch, 2 port view |
| regWe | input | 1 | Write enable, sampled at the rising edge |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for regAddr |
| pinIn | input | 8 | Asynchronous pin levels |
| pinOut | output | 8 | Output drive value for each pin |
| pinOe | output | 8 | Output enable for each pin |

## Verification
The output latch and the direction register both reach the ports without delay. A bad latch bit shows on pinOut and in the offset 1 read in the cycle after the faulty edge. A bad direction bit shows on pinOe at the same moment, and it also moves that bit of the port view between latch and pin. A fault in the synchronizer shows as a port-view bit that follows the pin one edge too early or too late. A wrongly gated write strobe shows as a register that changes during manual reset, software standby or hardware standby, or after a write to the read-only slot. Every such fault is visible on the next read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_DATA = 2'd1,
    RD_VIEW = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrData;
    rdSel_e rdSel;
  } portStrobe_t;

  localparam logic [1:0] OFS_DIR  = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_VIEW = 2'd2;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manualRstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output portStrobe_t       strobe
);
  logic writeAllowed;

  // Writes are blocked in every low-power or reset condition.
  assign writeAllowed = regWe && manualRstN && !swStandby && !hwStandby;

  always_comb begin
    strobe = '{wrDir: 1'b0, wrData: 1'b0, rdSel: RD_ZERO};
    unique case (regAddr)
      ADDR_W'(OFS_DIR):  strobe.wrDir  = writeAllowed;
      ADDR_W'(OFS_DATA): begin
        strobe.wrData = writeAllowed;
        strobe.rdSel  = RD_DATA;
      end
      ADDR_W'(OFS_VIEW): strobe.rdSel  = RD_VIEW;
      default:           strobe.rdSel  = RD_ZERO;
    endcase
  end

  // R6: the port view and the unused slot never produce a write strobe
  a_r6_no_view_write: assert property (@(posedge clk) disable iff (!porRstN)
    (regAddr >= ADDR_W'(OFS_VIEW)) |-> !(strobe.wrDir || strobe.wrData));
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0({strobe.wrDir, strobe.wrData}));
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             manualRstN,
  input  logic             hwStandby,
  input  logic             swStandby,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  localparam int LAST = SYNC_STAGE - 1;

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] syncChain [SYNC_STAGE];
  logic [WIDTH-1:0] pinSync;
  logic [WIDTH-1:0] portView;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      dirReg  <= '0;
      dataReg <= '0;
    end else if (hwStandby) begin
      dirReg  <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.wrDir)  dirReg  <= wrData;
      if (strobe.wrData) dataReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      for (int s = 0; s < SYNC_STAGE; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGE; s++) syncChain[s] <= syncChain[s-1];
    end
  end
  assign pinSync = syncChain[LAST];

  for (genvar b = 0; b < WIDTH; b++) begin : g_viewBit
    assign portView[b] = dirReg[b] ? dataReg[b] : pinSync[b];
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_DATA: rdData = dataReg;
      RD_VIEW: rdData = portView;
      default: rdData = '0;
    endcase
  end

  assign pinOut = dataReg;
  assign pinOe  = hwStandby ? '0 : dirReg;

  // R7: standby clears both registers at the next edge
  a_r7_hw_clear: assert property (@(posedge clk) disable iff (!porRstN)
    hwStandby |=> (dirReg == '0) && (dataReg == '0));
  // R8: manual reset holds both registers
  a_r8_hold_manual: assert property (@(posedge clk) disable iff (!porRstN)
    (!manualRstN && !hwStandby) |=> $stable(dirReg) && $stable(dataReg));
  // R9: software standby holds both registers
  a_r9_hold_sw: assert property (@(posedge clk) disable iff (!porRstN)
    (swStandby && !hwStandby) |=> $stable(dirReg) && $stable(dataReg));
  // R2: a data strobe loads the write data
  a_r2_data_load: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.wrData |=> dataReg == $past(wrData));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manualRstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [WIDTH-1:0]  regWdata,
  output logic [WIDTH-1:0]  regRdata,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe
);
  portStrobe_t strobe;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .manualRstN(manualRstN),
    .hwStandby(hwStandby), .swStandby(swStandby),
    .regAddr(regAddr), .regWe(regWe), .strobe(strobe)
  );

  gpio_port_dp #(.WIDTH(WIDTH), .SYNC_STAGE(2)) u_dp (
    .clk(clk), .porRstN(porRstN), .manualRstN(manualRstN),
    .hwStandby(hwStandby), .swStandby(swStandby),
    .strobe(strobe), .wrData(regWdata), .pinIn(pinIn),
    .rdData(regRdata), .pinOut(pinOut), .pinOe(pinOe)
  );

  // R7: no pin is driven during hardware standby
  a_r7_float: assert property (@(posedge clk) disable iff (!porRstN)
    hwStandby |-> pinOe == '0);
endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       manualRstN = 1'b1;
  logic       hwStandby = 1'b0;
  logic       swStandby = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic [7:0] pinIn = 8'h00;
  logic [7:0] pinOut;
  logic [7:0] pinOe;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_regs u_dut (
    .clk(clk), .porRstN(porRstN), .manualRstN(manualRstN),
    .hwStandby(hwStandby), .swStandby(swStandby),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic tPowerOn();
    logic [7:0] v;
    porRstN = 1'b0;
    repeat (2) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    check("R1 oe", pinOe, 8'h00);
    check("R1 out", pinOut, 8'h00);
    rd(2'd1, v); check("R1 data", v, 8'h00);
  endtask

  task automatic tDataDir();
    logic [7:0] v;
    wr(2'd1, 8'hA5);
    rd(2'd1, v); check("R2 data rd", v, 8'hA5);
    check("R2 pinOut", pinOut, 8'hA5);
    wr(2'd0, 8'h3C);
    check("R3 pinOe", pinOe, 8'h3C);
    rd(2'd0, v); check("R3 dir reads zero", v, 8'h00);
  endtask

  task automatic tPortView();
    logic [7:0] v;
    pinIn = 8'h0F;
    @(negedge clk); @(negedge clk);
    rd(2'd2, v); check("R4 mix", v, (8'hA5 & 8'h3C) | (8'h0F & ~8'h3C));
    wr(2'd0, 8'hFF);
    rd(2'd2, v); check("R4 all out", v, 8'hA5);
    wr(2'd0, 8'h00);
    rd(2'd2, v); check("R4 all in", v, 8'h0F);
  endtask

  task automatic tSync();
    logic [7:0] v;
    regAddr = 2'd2;
    @(negedge clk);
    pinIn = 8'hF0;
    @(negedge clk);
    rd(2'd2, v); check("R5 one edge", v, 8'h0F);
    @(negedge clk);
    rd(2'd2, v); check("R5 two edges", v, 8'hF0);
  endtask

  task automatic tReadOnly();
    logic [7:0] v;
    wr(2'd1, 8'h5A);
    wr(2'd0, 8'hC3);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h00);
    rd(2'd1, v); check("R6 data kept", v, 8'h5A);
    check("R6 dir kept", pinOe, 8'hC3);
    rd(2'd3, v); check("R6 unused reads zero", v, 8'h00);
  endtask

  task automatic tManual();
    logic [7:0] v;
    @(negedge clk); manualRstN = 1'b0;
    wr(2'd1, 8'h11);
    wr(2'd0, 8'h22);
    @(negedge clk); manualRstN = 1'b1;
    @(negedge clk);
    rd(2'd1, v); check("R8 data kept", v, 8'h5A);
    check("R8 dir kept", pinOe, 8'hC3);
  endtask

  task automatic tSoft();
    logic [7:0] v;
    @(negedge clk); swStandby = 1'b1;
    wr(2'd1, 8'h77);
    wr(2'd0, 8'h01);
    rd(2'd1, v); check("R9 data kept", v, 8'h5A);
    check("R9 dir kept", pinOe, 8'hC3);
    @(negedge clk); swStandby = 1'b0;
  endtask

  task automatic tHard();
    logic [7:0] v;
    @(negedge clk); hwStandby = 1'b1;
    #1 check("R7 oe off same cycle", pinOe, 8'h00);
    wr(2'd1, 8'hEE);
    rd(2'd1, v); check("R7 data cleared", v, 8'h00);
    check("R7 pinOut cleared", pinOut, 8'h00);
    @(negedge clk); hwStandby = 1'b0;
    @(negedge clk);
    check("R7 dir cleared", pinOe, 8'h00);
    rd(2'd2, v); check("R7 view is pins", v, pinIn);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tPowerOn();
    tDataDir();
    tPortView();
    tSync();
    tReadOnly();
    tManual();
    tSoft();
    tHard();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule